// File: doc/BRIEF.md
# Serial Register Access Port

This block is a clocked serial slave that gives an external host read and write access to a small bank of 16-bit registers. The host lowers the select line, clocks in a 16-bit command word and then a 16-bit data word, most significant bit first. The command word names the register and the direction. During the data phase the block shifts the register's current contents back to the host. On a write, the shifted-in data word replaces the register when the 32nd bit has been clocked.

The serial clock, select and data lines are synchronized into the system clock domain. The block samples host data on the detected rising serial-clock edge and changes its output on the detected falling edge. The bank holds three output setpoint words and a four-bit control word, both driven out of the block. It also maps a set of measurement words that are fed in from outside and can be read at any time. A synchronous active-low reset restores every stored register to its default.

Top module: `spi_regport`

## Requirements
- R1: While `ss_n` is high, serial-clock edges and MOSI data are ignored, and the next frame starts at command bit 15 with no leftover state.
- R2: `miso_oe` is 0 whenever `ss_n` is high and 1 whenever `ss_n` is low.
- R3: A frame is a 16-bit command followed by a 16-bit data word, both MSB first. Command bit 15 is the direction (1 = read, 0 = write) and bits 3:0 are the register index. If any of bits 14:4 is set, the access is unmapped. MISO is 0 during the command phase.
- R4: In a write frame, MISO returns the register's old value MSB first during the data phase. The register takes the new MOSI word only once the 32nd bit has been clocked.
- R5: In a read frame, the data-phase MOSI bits have no effect, MISO returns the addressed value MSB first, and no register changes.
- R6: Index map: 0 to 2 are 16-bit setpoints. Index 3 is the control word; only bits 3:0 are stored and bits 15:4 read 0. Indices 4 to 11 return measurement inputs 0 to 7 and ignore writes. Indices 12 to 15 read 0 and ignore writes.
- R7: When `rst_n` is low at a clock edge, all setpoints become 0x0000 and the control word becomes 0x000F.
- R8: A frame ended by `ss_n` rising before the 32nd bit changes no register.
- R9: `setpt_out` slice k (bits 16k+15:16k) equals setpoint k. `ctrl_out` equals the control word, with the following bit meanings: bit0 first switch disabled, bit1 second switch disabled, bit2 bipolar range, bit3 soft start enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idle low |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| meas_in | input | 128 | Eight 16-bit measurement words, word k at bits 16k+15:16k |
| setpt_out | output | 48 | Three 16-bit setpoint words |
| ctrl_out | output | 4 | Control word bits |

## Verification
Two functions fall into the same frame. In a write frame, the old value is shifted out while the new value is shifted in, and the register commit must not reach MISO before the last bit has been sent. The bench sweeps every index with distinct patterns over two passes and compares each returned word with the value it expects from the previous pass. It then reads the register back to confirm that the commit happened. Frames cut off at 20 and 31 bits check that the commit comes only with the 32nd rising edge.

// File: rtl/spi_regport_pkg.sv
// Package: shared constants and types for the serial register access port.
// Assumes a 16-bit command word with the direction bit at the MSB.
package spi_regport_pkg;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } xfer_dir_e;

    // Control word layout: bit positions decoded by the neighbouring analog logic
    localparam int CTRL_BITS       = 4;
    localparam int CTRL_SW1_OFF    = 0;
    localparam int CTRL_SW2_OFF    = 1;
    localparam int CTRL_BIPOLAR    = 2;
    localparam int CTRL_SOFTSTART  = 3;
    localparam logic [CTRL_BITS-1:0] CTRL_DEFAULT = 4'b1111;

endpackage

// File: rtl/spi_sync_bits.sv
// Module: multi-stage synchronizer for a group of asynchronous single-bit inputs.
// Assumes each bit is independent; STAGES >= 2. Reset loads RST_VAL.
module spi_sync_bits #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Purpose: one flop stage of the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[s] <= RST_VAL;
            else if (s == 0)
                chain[s] <= d_async;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
// Module: frame sequencer. Counts serial bits, collects the command and data
// words, loads the read word for transmission and issues one commit pulse on
// a complete write frame. Assumes synchronized inputs and an idle-low serial clock.
module spi_frame #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              ss_n_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-2:0] acc_addr,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              miso_bit
);
    import spi_regport_pkg::*;

    localparam int CNT_W = $clog2(2*WORD_W + 1);
    localparam logic [CNT_W-1:0] CMD_END  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(2*WORD_W - 1);
    localparam logic [CNT_W-1:0] FRM_END  = CNT_W'(2*WORD_W);

    logic              sclk_prev;
    logic              rise, fall, active;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] cmd_sr;
    logic [WORD_W-1:0] data_sr;
    logic [WORD_W-1:0] tx_sr;
    xfer_dir_e         dir;

    assign rise   = sclk_s & ~sclk_prev;
    assign fall   = ~sclk_s & sclk_prev;
    assign active = ~ss_n_s;
    assign dir    = xfer_dir_e'(cmd_sr[WORD_W-1]);

    // Purpose: remember the previous synchronized clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    // Purpose: bit counting, word capture, transmit shifting and write commit
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt <= '0;
            cmd_sr  <= '0;
            data_sr <= '0;
            tx_sr   <= '0;
            wr_en   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (rise && bit_cnt < FRM_END) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt < CMD_END)
                    cmd_sr <= {cmd_sr[WORD_W-2:0], mosi_s};
                else
                    data_sr <= {data_sr[WORD_W-2:0], mosi_s};
                if (bit_cnt == FRM_LAST && dir == DIR_WRITE)
                    wr_en <= 1'b1;
            end
            if (fall) begin
                if (bit_cnt == CMD_END)
                    tx_sr <= rd_data;
                else if (bit_cnt > CMD_END)
                    tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign acc_addr = cmd_sr[WORD_W-2:0];
    assign wr_data  = data_sr;
    assign miso_bit = tx_sr[WORD_W-1];

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (bit_cnt == '0)); // R1
    AST_TX_QUIET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt < CMD_END) |-> (tx_sr == '0)); // R3
    AST_COMMIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R4
    AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_cnt == FRM_END)); // R8
endmodule

// File: rtl/spi_regbank.sv
// Module: register bank. Holds setpoints and the control word, maps external
// measurement words read-only, and decodes unmapped accesses to zero.
// Assumes N_SETPT + 1 + N_MEAS <= 2**IDX_W and IDX_W < WORD_W-1.
module spi_regbank #(
    parameter int WORD_W  = 16,
    parameter int IDX_W   = 4,
    parameter int N_SETPT = 3,
    parameter int N_MEAS  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORD_W-2:0]         acc_addr,
    input  logic                      wr_en,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [N_MEAS*WORD_W-1:0]  meas_in,
    output logic [WORD_W-1:0]         rd_data,
    output logic [N_SETPT*WORD_W-1:0] setpt_out,
    output logic [spi_regport_pkg::CTRL_BITS-1:0] ctrl_out
);
    import spi_regport_pkg::*;

    localparam int AF_W    = WORD_W - 1;
    localparam int CTRL_IX = N_SETPT;
    localparam int MEAS_LO = N_SETPT + 1;

    logic              addr_ok;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] set_q [N_SETPT];
    logic [CTRL_BITS-1:0] ctrl_q;

    assign addr_ok = (acc_addr[AF_W-1:IDX_W] == '0);
    assign idx     = acc_addr[IDX_W-1:0];

    for (genvar g = 0; g < N_SETPT; g++) begin : g_setpt
        // Purpose: setpoint register g, cleared on reset, loaded by a commit
        always_ff @(posedge clk) begin
            if (!rst_n)
                set_q[g] <= '0;
            else if (wr_en && addr_ok && idx == IDX_W'(g))
                set_q[g] <= wr_data;
        end
        assign setpt_out[g*WORD_W +: WORD_W] = set_q[g];

        AST_SETPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr_ok && idx == IDX_W'(g)) |=> (set_q[g] == $past(wr_data))); // R4
    end

    // Purpose: control word, reset to its default, low bits loaded by a commit
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_DEFAULT;
        else if (wr_en && addr_ok && idx == IDX_W'(CTRL_IX))
            ctrl_q <= wr_data[CTRL_BITS-1:0];
    end
    assign ctrl_out = ctrl_q;

    // Purpose: read multiplexer over stored and mapped words
    always_comb begin
        rd_data = '0;
        if (addr_ok) begin
            for (int k = 0; k < N_SETPT; k++)
                if (idx == IDX_W'(k)) rd_data = set_q[k];
            if (idx == IDX_W'(CTRL_IX))
                rd_data = {{(WORD_W-CTRL_BITS){1'b0}}, ctrl_q};
            for (int k = 0; k < N_MEAS; k++)
                if (idx == IDX_W'(MEAS_LO + k)) rd_data = meas_in[k*WORD_W +: WORD_W];
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q)); // R5
    AST_CTRL_RESET: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == CTRL_DEFAULT)); // R7
endmodule

// File: rtl/spi_regport.sv
// Module: top of the serial register access port. Synchronizes the host lines,
// sequences frames and serves the register bank. Assumes the serial clock
// half-period spans at least five system clocks.
module spi_regport #(
    parameter int WORD_W  = 16,
    parameter int IDX_W   = 4,
    parameter int N_SETPT = 3,
    parameter int N_MEAS  = 8,
    parameter int SYNC_N  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk,
    input  logic                      ss_n,
    input  logic                      mosi,
    output logic                      miso,
    output logic                      miso_oe,
    input  logic [N_MEAS*WORD_W-1:0]  meas_in,
    output logic [N_SETPT*WORD_W-1:0] setpt_out,
    output logic [3:0]                ctrl_out
);
    logic              sclk_s, ss_n_s, mosi_s;
    logic [WORD_W-2:0] acc_addr;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data, rd_data;

    spi_sync_bits #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sclk, ss_n, mosi}),
        .q_sync  ({sclk_s, ss_n_s, mosi_s})
    );

    spi_frame #(.WORD_W(WORD_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .ss_n_s   (ss_n_s),
        .mosi_s   (mosi_s),
        .rd_data  (rd_data),
        .acc_addr (acc_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .miso_bit (miso)
    );

    spi_regbank #(.WORD_W(WORD_W), .IDX_W(IDX_W), .N_SETPT(N_SETPT), .N_MEAS(N_MEAS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (acc_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .meas_in   (meas_in),
        .rd_data   (rd_data),
        .setpt_out (setpt_out),
        .ctrl_out  (ctrl_out)
    );

    // Pad enable follows the raw select so the line is released without delay
    assign miso_oe = ~ss_n;
endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic ss_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;
    logic [127:0] meas_in;
    logic [47:0]  setpt_out;
    logic [3:0]   ctrl_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [15:0] m_sp [3];
    logic [3:0]  m_ctrl;

    spi_regport u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .meas_in(meas_in),
        .setpt_out(setpt_out), .ctrl_out(ctrl_out)
    );

    always #4 clk = ~clk;

    always_comb
        for (int k = 0; k < 8; k++) meas_in[k*16 +: 16] = 16'hA000 + 16'(k * 16'h0111);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int a);
        if (a < 3) return m_sp[a];
        if (a == 3) return {12'h000, m_ctrl};
        if (a < 12) return 16'hA000 + 16'((a - 4) * 16'h0111);
        return 16'h0000;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 3; k++) m_sp[k] = 16'h0000;
        m_ctrl = 4'hF;
    endtask

    task automatic xfer(input logic [15:0] cmd, input logic [15:0] dat,
                        input int nbits, output logic [15:0] rx);
        logic [31:0] frame;
        frame = {cmd, dat};
        rx = '0;
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 oe in frame", {47'b0, miso_oe}, 48'd1);
        for (int i = 0; i < nbits; i++) begin
            mosi = frame[31-i];
            repeat (H) @(negedge clk);
            if (i >= 16) rx[31-i] = miso;
            else if (i == 8) chk("R3 miso quiet in command", {47'b0, miso}, 48'd0);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [15:0] rx;
        logic [15:0] d;
        model_reset();
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 / R7 / R9: reset state at the ports
        chk("R2 oe idle", {47'b0, miso_oe}, 48'd0);
        chk("R7 R9 setpoints reset", setpt_out, 48'd0);
        chk("R7 R9 ctrl reset", {44'b0, ctrl_out}, 48'hF);

        // R5 R6 R7: read every index with junk data-phase bits
        for (int a = 0; a < 16; a++) begin
            xfer(16'h8000 | 16'(a), 16'hFFFF ^ 16'(a * 16'h1357), 32, rx);
            chk($sformatf("R5 R6 R7 read idx %0d", a), {32'b0, rx}, {32'b0, model(a)});
        end
        chk("R5 read leaves setpoints", setpt_out, 48'd0);

        // R3: reserved command bits make the access unmapped
        xfer(16'h8100 | 16'd3, 16'h0000, 32, rx);
        chk("R3 reserved bit read", {32'b0, rx}, 48'd0);
        xfer(16'h0200, 16'hFFFF, 32, rx);
        chk("R3 reserved bit write old", {32'b0, rx}, 48'd0);
        xfer(16'h8000, 16'h0000, 32, rx);
        chk("R3 reserved write ignored", {32'b0, rx}, {32'b0, model(0)});

        // R4 R6: two write passes, returned old value then read back
        for (int p = 1; p <= 2; p++) begin
            for (int a = 0; a < 16; a++) begin
                d = 16'h1234 ^ 16'(a * 16'h0F0F) ^ 16'(p * 16'h8421);
                xfer(16'(a), d, 32, rx);
                chk($sformatf("R4 old value p%0d idx %0d", p, a), {32'b0, rx}, {32'b0, model(a)});
                if (a < 3) m_sp[a] = d;
                else if (a == 3) m_ctrl = d[3:0];
                xfer(16'h8000 | 16'(a), 16'h0000, 32, rx);
                chk($sformatf("R4 R6 readback p%0d idx %0d", p, a), {32'b0, rx}, {32'b0, model(a)});
            end
            chk("R9 setpoint outputs", setpt_out, {m_sp[2], m_sp[1], m_sp[0]});
            chk("R9 ctrl outputs", {44'b0, ctrl_out}, {44'b0, m_ctrl});
        end

        // R8: aborted write frames
        xfer(16'h0000, 16'h5A5A, 20, rx);
        xfer(16'h0003, 16'h0005, 31, rx);
        xfer(16'h8000, 16'h0000, 32, rx);
        chk("R8 abort 20 bits", {32'b0, rx}, {32'b0, model(0)});
        xfer(16'h8003, 16'h0000, 32, rx);
        chk("R8 abort 31 bits", {32'b0, rx}, {32'b0, model(3)});

        // R1 R2: clock activity with select high is ignored
        for (int i = 0; i < 40; i++) begin
            mosi = i[0];
            sclk = 1'b1; repeat (H) @(negedge clk);
            chk("R2 oe deselected", {47'b0, miso_oe}, 48'd0);
            sclk = 1'b0; repeat (H) @(negedge clk);
        end
        xfer(16'h8001, 16'h0000, 32, rx);
        chk("R1 deselected clocks ignored", {32'b0, rx}, {32'b0, model(1)});
        chk("R1 setpoints intact", setpt_out, {m_sp[2], m_sp[1], m_sp[0]});

        // R7: reset after writes restores defaults
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        repeat (4) @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            xfer(16'h8000 | 16'(a), 16'hA5A5, 32, rx);
            chk($sformatf("R7 default idx %0d", a), {32'b0, rx}, {32'b0, model(a)});
        end
        chk("R7 R9 ctrl after reset", {44'b0, ctrl_out}, 48'hF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule